// File: doc/BRIEF.md
# Mixed-Sign Saturating SIMD Accumulator

This block adds an addend vector into an accumulator vector whose elements have the opposite signedness. Each lane saturates on its own. There are two operations. In the first, the accumulator lane is unsigned and the addend lane is signed. In the second, the accumulator lane is signed and the addend lane is unsigned. In both, the result is clamped to the range of the accumulator's type. Lanes can be 8, 16, 32 or 64 bits wide across a 128-bit datapath.

In vector mode every lane of the 128-bit word is computed. In scalar mode only the lowest lane is computed, and every bit above it is returned as zero. A sticky flag collects a saturation event from any lane that took part. The flag keeps its value until a dedicated clear input resets it.

The result, the done strobe and the flag are all registered. The done strobe and the new result appear on the clock edge that follows a start request.

Top module: `sat_mixed_acc`

## Requirements
- R1: With `op_i`=0, each accumulator lane is unsigned and each addend lane is two's-complement signed. The lane result is the exact sum clamped to the range 0 to 2^n-1.
- R2: With `op_i`=1, each accumulator lane is two's-complement signed and each addend lane is unsigned. The lane result is the exact sum clamped to the range -2^(n-1) to 2^(n-1)-1.
- R3: `size_i` selects the lane width: 0 selects 8 bits, 1 selects 16, 2 selects 32 and 3 selects 64. Lane k occupies bits [k*n +: n]. Each lane saturates independently of its neighbours.
- R4: In 64-bit lanes with `op_i`=0, a non-negative addend whose sum wraps past 2^64-1 gives all ones. A negative addend whose magnitude exceeds the accumulator gives zero.
- R5: In 64-bit lanes with `op_i`=1, the addend is first limited to (2^63-1) minus the accumulator. Saturation is reported exactly when that limit was applied, and the result is then 2^63-1.
- R6: The sticky flag `sat_o` is set by any started operation in which a participating lane's clamped value differs from its exact sum. Once set, it stays at 1 through later operations that do not saturate.
- R7: `clr_i` resets the sticky flag to 0 on the next clock edge. When `clr_i` and a saturating start occur in the same cycle, the flag ends at 0, and the result is still updated.
- R8: With `scalar_i`=1, only lane 0 is computed, and all result bits above lane 0 are 0. Only lane 0 can raise the flag.
- R9: With `scalar_i`=0, all 128/n lanes are computed.
- R10: `done_o` is 1 for exactly the one cycle after a cycle in which `start_i`=1. `res_o` changes only on that edge and holds its value otherwise.
- R11: After reset, `res_o`, `done_o` and `sat_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start one accumulate operation this cycle |
| op_i | input | 1 | 0: unsigned accumulator and signed addend; 1: signed accumulator and unsigned addend |
| size_i | input | 2 | Lane width select (0:8, 1:16, 2:32, 3:64 bits) |
| scalar_i | input | 1 | 1: lowest lane only; 0: all lanes |
| acc_i | input | 128 | Accumulator operand |
| add_i | input | 128 | Addend operand |
| clr_i | input | 1 | Synchronous clear of the sticky saturation flag |
| res_o | output | 128 | Registered result |
| done_o | output | 1 | One-cycle strobe marking a new result |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
The bench targets the sums that land exactly on a range limit, such as a signed minimum plus the largest unsigned addend. A design that compared against the wrong limit would falsely flag these sums or clamp them. The 64-bit lanes are driven where the sum just wraps and where the negative addend has the largest magnitude, because a design that reused a narrow widened-sum approach there would return wrapped values. Mixed lanes in a single word expose carries or clamps that leak between lanes. Scalar operations with saturating upper lanes expose a design that leaves stale upper bits in the result or lets those lanes raise the flag. A clear issued in the same cycle as a saturating start shows whether the design gives the set priority over the clear.

// File: rtl/sat_acc_pkg.sv
package sat_acc_pkg;

    localparam int WIDE_W = 64;

    typedef enum logic {
        OP_UACC = 1'b0,
        OP_SACC = 1'b1
    } acc_op_e;

    typedef enum logic [1:0] {
        LW8  = 2'd0,
        LW16 = 2'd1,
        LW32 = 2'd2,
        LW64 = 2'd3
    } lane_sel_e;

    function automatic int lane_bits(input int sel);
        return 8 << sel;
    endfunction

endpackage

// File: rtl/sat_lane_narrow.sv
module sat_lane_narrow
    import sat_acc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         op_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] add_i,
    output logic [W-1:0] res_o,
    output logic         sat_o
);
    localparam int XW = W + 2;

    logic signed [XW-1:0] acc_x;
    logic signed [XW-1:0] add_x;
    logic signed [XW-1:0] sum_x;
    logic signed [XW-1:0] hi_x;
    logic signed [XW-1:0] lo_x;
    logic signed [XW-1:0] clamp_x;

    always_comb begin
        if (op_i == OP_UACC) begin
            acc_x = $signed({2'b00, acc_i});
            add_x = $signed({{2{add_i[W-1]}}, add_i});
            hi_x  = $signed({2'b00, {W{1'b1}}});
            lo_x  = '0;
        end else begin
            acc_x = $signed({{2{acc_i[W-1]}}, acc_i});
            add_x = $signed({2'b00, add_i});
            hi_x  = $signed({3'b000, {(W-1){1'b1}}});
            lo_x  = $signed({3'b111, {(W-1){1'b0}}});
        end
        sum_x = acc_x + add_x;
        if (sum_x > hi_x) begin
            clamp_x = hi_x;
        end else if (sum_x < lo_x) begin
            clamp_x = lo_x;
        end else begin
            clamp_x = sum_x;
        end
        res_o = clamp_x[W-1:0];
        sat_o = (clamp_x != sum_x);
    end
endmodule

// File: rtl/sat_lane_wide.sv
module sat_lane_wide
    import sat_acc_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         op_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] add_i,
    output logic [W-1:0] res_o,
    output logic         sat_o
);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};

    logic [W-1:0] wrap_sum;
    logic [W-1:0] neg_add;
    logic [W-1:0] headroom;
    logic [W-1:0] lim_add;

    always_comb begin
        wrap_sum = acc_i + add_i;
        neg_add  = (~add_i) + 1'b1;
        headroom = SMAX - acc_i;
        lim_add  = (add_i < headroom) ? add_i : headroom;
        res_o    = wrap_sum;
        sat_o    = 1'b0;
        if (op_i == OP_UACC) begin
            if (!add_i[W-1]) begin
                if (wrap_sum < acc_i) begin
                    res_o = '1;
                    sat_o = 1'b1;
                end
            end else if (acc_i < neg_add) begin
                res_o = '0;
                sat_o = 1'b1;
            end
        end else begin
            res_o = acc_i + lim_add;
            sat_o = (lim_add != add_i);
        end
    end
endmodule

// File: rtl/sat_lane_array.sv
module sat_lane_array
    import sat_acc_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int LANE_W = 8
) (
    input  logic              op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] add_i,
    output logic [DATA_W-1:0] res_o,
    output logic              sat_any_o,
    output logic              sat_low_o
);
    localparam int LANES = DATA_W / LANE_W;

    logic [LANES-1:0] lane_sat;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        if (LANE_W >= WIDE_W) begin : g_wide
            sat_lane_wide #(.W(LANE_W)) i_lane (
                .op_i  (op_i),
                .acc_i (acc_i[k*LANE_W +: LANE_W]),
                .add_i (add_i[k*LANE_W +: LANE_W]),
                .res_o (res_o[k*LANE_W +: LANE_W]),
                .sat_o (lane_sat[k])
            );
        end else begin : g_narrow
            sat_lane_narrow #(.W(LANE_W)) i_lane (
                .op_i  (op_i),
                .acc_i (acc_i[k*LANE_W +: LANE_W]),
                .add_i (add_i[k*LANE_W +: LANE_W]),
                .res_o (res_o[k*LANE_W +: LANE_W]),
                .sat_o (lane_sat[k])
            );
        end
    end

    assign sat_any_o = |lane_sat;
    assign sat_low_o = lane_sat[0];
endmodule

// File: rtl/sat_mixed_acc.sv
module sat_mixed_acc
    import sat_acc_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_i,
    input  logic [1:0]        size_i,
    input  logic              scalar_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] add_i,
    input  logic              clr_i,
    output logic [DATA_W-1:0] res_o,
    output logic              done_o,
    output logic              sat_o
);
    localparam int NSIZES = 4;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              done;
        logic              sat;
    } acc_state_t;

    acc_state_t st_d, st_q;

    logic [DATA_W-1:0] res_by_size [NSIZES];
    logic              any_by_size [NSIZES];
    logic              low_by_size [NSIZES];

    for (genvar s = 0; s < NSIZES; s++) begin : g_size
        sat_lane_array #(
            .DATA_W (DATA_W),
            .LANE_W (lane_bits(s))
        ) i_arr (
            .op_i      (op_i),
            .acc_i     (acc_i),
            .add_i     (add_i),
            .res_o     (res_by_size[s]),
            .sat_any_o (any_by_size[s]),
            .sat_low_o (low_by_size[s])
        );
    end

    logic [DATA_W-1:0] low_mask;
    logic [DATA_W-1:0] calc_res;
    logic              calc_sat;

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            low_mask[i] = (i < lane_bits(int'(size_i)));
        end
        if (scalar_i) begin
            calc_res = res_by_size[size_i] & low_mask;
            calc_sat = low_by_size[size_i];
        end else begin
            calc_res = res_by_size[size_i];
            calc_sat = any_by_size[size_i];
        end

        st_d      = st_q;
        st_d.done = start_i;
        if (start_i) begin
            st_d.res = calc_res;
            st_d.sat = st_q.sat | calc_sat;
        end
        if (clr_i) begin
            st_d.sat = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o  = st_q.res;
    assign done_o = st_q.done;
    assign sat_o  = st_q.sat;
endmodule

// File: rtl/sat_acc_chk.sv
module sat_acc_chk #(
    parameter int DATA_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              scalar_i,
    input logic              clr_i,
    input logic [DATA_W-1:0] res_o,
    input logic              done_o,
    input logic              sat_o
);
    p_done_follows_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);

    p_res_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(res_o));

    p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !sat_o);

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_o && !clr_i) |=> sat_o);

    p_flag_needs_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sat_o && !start_i) |=> !sat_o);

    p_scalar_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && scalar_i) |=> (res_o[DATA_W-1:64] == '0));
endmodule

bind sat_mixed_acc sat_acc_chk #(.DATA_W(DATA_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .scalar_i (scalar_i),
    .clr_i    (clr_i),
    .res_o    (res_o),
    .done_o   (done_o),
    .sat_o    (sat_o)
);

// File: tb/test_sat_mixed_acc.sv
module test_sat_mixed_acc;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 128;

    typedef struct packed {
        logic          op;
        logic [1:0]    size;
        logic          scalar;
        logic [DW-1:0] acc;
        logic [DW-1:0] add;
        logic [DW-1:0] exp;
        logic          sat;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        // R1 R3: 8-bit lanes, unsigned overflow clamps to FF
        '{1'b0, 2'd0, 1'b0, {16{8'hF0}}, {16{8'h20}}, {16{8'hFF}}, 1'b1},
        // R1: negative addend reaching exactly zero
        '{1'b0, 2'd0, 1'b0, {16{8'h10}}, {16{8'hF0}}, {16{8'h00}}, 1'b0},
        // R1: negative addend below zero clamps to 0
        '{1'b0, 2'd0, 1'b0, {16{8'h10}}, {16{8'hE0}}, {16{8'h00}}, 1'b1},
        // R2 R3: 16-bit signed overflow
        '{1'b1, 2'd1, 1'b0, {8{16'h7FF0}}, {8{16'h0020}}, {8{16'h7FFF}}, 1'b1},
        // R2: signed minimum plus max unsigned lands on max exactly
        '{1'b1, 2'd1, 1'b0, {8{16'h8000}}, {8{16'hFFFF}}, {8{16'h7FFF}}, 1'b0},
        // R1 R3: 32-bit lanes exact zero
        '{1'b0, 2'd2, 1'b0, {4{32'h0000_0005}}, {4{32'hFFFF_FFFB}}, {4{32'h0}}, 1'b0},
        // R3 R9: mixed 32-bit lanes, only top lane saturates
        '{1'b1, 2'd2, 1'b0, {32'h7FFF_FFFF, 32'h1, 32'h8000_0000, 32'h0},
              {32'h1, 32'h2, 32'hFFFF_FFFF, 32'h0},
              {32'h7FFF_FFFF, 32'h3, 32'h7FFF_FFFF, 32'h0}, 1'b1},
        // R4: 64-bit wrap to all ones and negative clamp to zero
        '{1'b0, 2'd3, 1'b0, {64'hFFFF_FFFF_FFFF_FFF0, 64'h5},
              {64'h20, 64'hFFFF_FFFF_FFFF_FFFA},
              {64'hFFFF_FFFF_FFFF_FFFF, 64'h0}, 1'b1},
        // R4: exact zero and exact all-ones without saturation
        '{1'b0, 2'd3, 1'b0, {64'h100, 64'h8000_0000_0000_0000},
              {64'hFFFF_FFFF_FFFF_FF00, 64'h7FFF_FFFF_FFFF_FFFF},
              {64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, 1'b0},
        // R5: limited addend saturates; full-range addend exact
        '{1'b1, 2'd3, 1'b0, {64'h7FFF_FFFF_FFFF_FFFE, 64'h8000_0000_0000_0000},
              {64'h2, 64'hFFFF_FFFF_FFFF_FFFF},
              {64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF}, 1'b1},
        // R5: ordinary signed sums
        '{1'b1, 2'd3, 1'b0, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
              {64'h10, 64'h1234}, {64'hF, 64'h1234}, 1'b0},
        // R8: scalar 8-bit, upper bits zeroed
        '{1'b0, 2'd0, 1'b1, {{15{8'hFF}}, 8'hF0}, {{15{8'h01}}, 8'h20},
              {120'h0, 8'hFF}, 1'b1},
        // R8: scalar 16-bit, saturating upper lanes do not flag
        '{1'b1, 2'd1, 1'b1, {{7{16'h7FFF}}, 16'h0001}, {{7{16'h0001}}, 16'h0002},
              {112'h0, 16'h0003}, 1'b0},
        // R8: scalar 64-bit
        '{1'b0, 2'd3, 1'b1, {64'hFFFF_FFFF_FFFF_FFFF, 64'h7}, {64'h1, 64'h3},
              {64'h0, 64'hA}, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          op_i = 1'b0;
    logic [1:0]    size_i = 2'd0;
    logic          scalar_i = 1'b0;
    logic [DW-1:0] acc_i = '0;
    logic [DW-1:0] add_i = '0;
    logic          clr_i = 1'b0;
    logic [DW-1:0] res_o;
    logic          done_o;
    logic          sat_o;

    int n_checks = 0;
    int n_fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sat_mixed_acc #(.DATA_W(DW)) i_sat_mixed_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .op_i     (op_i),
        .size_i   (size_i),
        .scalar_i (scalar_i),
        .acc_i    (acc_i),
        .add_i    (add_i),
        .clr_i    (clr_i),
        .res_o    (res_o),
        .done_o   (done_o),
        .sat_o    (sat_o)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic op, input logic [1:0] sz, input logic sc,
                          input logic [DW-1:0] a, input logic [DW-1:0] b, input logic clr);
        @(negedge clk);
        start_i  = 1'b1;
        op_i     = op;
        size_i   = sz;
        scalar_i = sc;
        acc_i    = a;
        add_i    = b;
        clr_i    = clr;
        @(negedge clk);
        start_i = 1'b0;
        clr_i   = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R11: reset state
        check("R11 res", res_o, '0);
        check("R11 done", {127'h0, done_o}, '0);
        check("R11 sat", {127'h0, sat_o}, '0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            pulse_clear();
            run_op(VECS[v].op, VECS[v].size, VECS[v].scalar, VECS[v].acc, VECS[v].add, 1'b0);
            check($sformatf("R1-vector %0d result (R2 R3 R4 R5 R8 R9)", v), res_o, VECS[v].exp);
            check($sformatf("R10 done vector %0d", v), {127'h0, done_o}, {127'h0, 1'b1});
            check($sformatf("R6 flag vector %0d", v), {127'h0, sat_o}, {127'h0, VECS[v].sat});
        end

        // R10: done drops and result holds with no start
        @(negedge clk);
        check("R10 done low", {127'h0, done_o}, '0);
        check("R10 hold", res_o, {64'h0, 64'hA});

        // R6: sticky across a later non-saturating op
        pulse_clear();
        run_op(1'b0, 2'd0, 1'b0, {16{8'hF0}}, {16{8'h20}}, 1'b0);
        check("R6 set", {127'h0, sat_o}, {127'h0, 1'b1});
        run_op(1'b0, 2'd0, 1'b0, {16{8'h01}}, {16{8'h01}}, 1'b0);
        check("R6 sticky result", res_o, {16{8'h02}});
        check("R6 sticky flag", {127'h0, sat_o}, {127'h0, 1'b1});

        // R7: clear beats same-cycle saturation, result still updates
        run_op(1'b1, 2'd1, 1'b0, {8{16'h7FF0}}, {8{16'h0020}}, 1'b1);
        check("R7 clear priority flag", {127'h0, sat_o}, '0);
        check("R7 result updated", res_o, {8{16'h7FFF}});

        // R7: plain clear
        run_op(1'b0, 2'd2, 1'b0, {4{32'h1}}, {4{32'hFFFF_FFF0}}, 1'b0);
        check("R7 set again", {127'h0, sat_o}, {127'h0, 1'b1});
        pulse_clear();
        check("R7 cleared", {127'h0, sat_o}, '0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule